// File: doc/BRIEF.md
# Return Address Shadow Stack Coprocessor

This block sits next to a CPU core and keeps a separate hardware copy of function return addresses. The core sends it 32-bit custom instruction words on a command handshake, together with the 64-bit value of the first source register. A call-type command pushes that value onto an on-chip stack. A return-type command pops the top entry and sends it back on a response handshake, tagged with the destination register index, so software can compare it with the link register and trap on a mismatch.

Commands first enter a small FIFO, so the core can issue them back to back. A push never answers, so the core does not wait on it. A pop answers only when the command asks for a result. Words that carry another opcode or an unknown function code raise a one-cycle illegal-instruction pulse and leave the stack untouched. A push onto a full stack or a pop from an empty one sets a sticky error flag. An empty pop returns zero, which never equals a real return address.

Top module: `retstack_cop`

## Requirements
- R1: A command is decoded from inst[6:0] (opcode), inst[11:7] (rd), inst[14] (xd) and inst[31:25] (funct7). It is valid only with opcode 7'b0001011. funct7 0 is a push and funct7 1 is a pop. So 0x0002a00b is a push and 0x0200428b is a pop that answers to register 5.
- R2: A push stores cmd_rs1 as the new top entry and produces no response.
- R3: A pop with xd=1 removes the top entry and returns it on rsp_data with rsp_rd equal to the command's rd field. Entries come back in last-in, first-out order.
- R4: A pop with xd=0 removes the top entry without producing a response.
- R5: Accepted commands are executed in arrival order, none is lost. cmd_ready goes low only while the QDEPTH-entry command queue is full.
- R6: rsp_valid, rsp_data and rsp_rd stay unchanged until rsp_ready is seen high. No queued command executes while a response is pending.
- R7: A command with any other opcode, or with a funct7 other than 0 or 1, raises illegal for exactly one cycle and does not change the stack.
- R8: The stack holds DEPTH entries (default 1024, 64 bits wide). A push while it is full is dropped, leaves the contents intact and sets err.
- R9: A pop from an empty stack returns zero when xd=1, sets err and leaves the stack empty.
- R10: err stays set until reset. Reset empties the stack and clears err, illegal and rsp_valid.

Top module ports in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command queue can accept |
| cmd_inst | input | 32 | Custom instruction word |
| cmd_rs1 | input | XLEN | First source operand (return address) |
| rsp_valid | output | 1 | Pop result available |
| rsp_ready | input | 1 | Core accepts the result |
| rsp_rd | output | 5 | Destination register of the result |
| rsp_data | output | XLEN | Popped return address |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
Several rules are checked by assertions on every cycle: the response holds steady under backpressure, no command is dequeued while a response waits, err never clears without reset, the fill count stays within DEPTH, an illegal pulse leaves the fill count as it was, and an empty pop answers with zero. The bench scenarios are needed for behaviour that depends on stored data and ordering. These cover LIFO order across interleaved pushes and pops, the exact drop of the 1025th push, queue ordering while a response is stalled, the silent pop with xd=0, and the decoding of the two fixed instruction words.

// File: rtl/rsk_pkg.sv
`timescale 1ns/1ps
package rsk_pkg;
    localparam int XLEN = 64;
    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
    localparam logic [6:0] F7_PUSH = 7'd0;
    localparam logic [6:0] F7_POP  = 7'd1;

    typedef enum logic [1:0] {OP_PUSH, OP_POP, OP_BAD} op_e;

    typedef struct packed {
        logic [31:0]     inst;
        logic [XLEN-1:0] rs1;
    } cmd_t;

    typedef struct packed {
        op_e        op;
        logic [4:0] rd;
        logic       want_rsp;
    } dec_t;

    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        d.rd       = w[11:7];
        d.want_rsp = w[14];
        if (w[6:0] != OPC_CUSTOM0)      d.op = OP_BAD;
        else if (w[31:25] == F7_PUSH)   d.op = OP_PUSH;
        else if (w[31:25] == F7_POP)    d.op = OP_POP;
        else                            d.op = OP_BAD;
        return d;
    endfunction
endpackage

// File: rtl/rsk_cmd_fifo.sv
`timescale 1ns/1ps
module rsk_cmd_fifo
    import rsk_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  cmd_t in_cmd,
    output logic out_valid,
    input  logic out_take,
    output cmd_t out_cmd
);
    localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int NW = $clog2(QDEPTH + 1);

    cmd_t          slot [QDEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [NW-1:0] fill;
    logic          do_wr, do_rd;

    assign in_ready  = (fill != NW'(QDEPTH));
    assign out_valid = (fill != '0);
    assign do_wr     = in_valid && in_ready;
    assign do_rd     = out_take && out_valid;
    assign out_cmd   = slot[rptr];

    for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_wr && (wptr == PW'(i))) slot[i] <= in_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == PW'(QDEPTH - 1)) ? '0 : wptr + PW'(1);
            if (do_rd) rptr <= (rptr == PW'(QDEPTH - 1)) ? '0 : rptr + PW'(1);
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + NW'(1);
                2'b01:   fill <= fill - NW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/rsk_decode.sv
`timescale 1ns/1ps
module rsk_decode
    import rsk_pkg::*;
(
    input  logic [31:0] inst,
    output dec_t        dec
);
    always_comb dec = decode_word(inst);
endmodule

// File: rtl/rsk_stack.sv
`timescale 1ns/1ps
module rsk_stack
    import rsk_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_en,
    input  logic            pop_en,
    input  logic [XLEN-1:0] push_data,
    output logic [XLEN-1:0] top_data,
    output logic            empty,
    output logic            full,
    output logic [CW-1:0]   cnt
);
    logic [XLEN-1:0] mem [DEPTH];
    logic [CW-1:0]   tos_next;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign tos_next = cnt + CW'(1);
    assign top_data = empty ? '0 : mem[AW'(cnt - CW'(1))];

    always_ff @(posedge clk) begin
        if (push_en && !full) mem[AW'(tos_next - CW'(1))] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push_en && !full) begin
            cnt <= tos_next;
        end else if (pop_en && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/retstack_cop.sv
`timescale 1ns/1ps
module retstack_cop
    import rsk_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int QDEPTH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [31:0]     cmd_inst,
    input  logic [XLEN-1:0] cmd_rs1,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [4:0]      rsp_rd,
    output logic [XLEN-1:0] rsp_data,
    output logic            illegal,
    output logic            err
);
    localparam int CW = $clog2(DEPTH + 1);

    cmd_t            in_cmd, head;
    logic            head_valid, deq;
    dec_t            dec;
    logic            push_en, pop_en;
    logic [XLEN-1:0] top_data;
    logic            stk_empty, stk_full;
    logic [CW-1:0]   stk_cnt;

    assign in_cmd.inst = cmd_inst;
    assign in_cmd.rs1  = cmd_rs1;

    rsk_cmd_fifo #(.QDEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .in_valid(cmd_valid), .in_ready(cmd_ready), .in_cmd(in_cmd),
        .out_valid(head_valid), .out_take(deq), .out_cmd(head)
    );

    rsk_decode u_dec (.inst(head.inst), .dec(dec));

    assign deq     = head_valid && !rsp_valid;
    assign push_en = deq && (dec.op == OP_PUSH);
    assign pop_en  = deq && (dec.op == OP_POP);

    rsk_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push_en(push_en), .pop_en(pop_en), .push_data(head.rs1),
        .top_data(top_data), .empty(stk_empty), .full(stk_full), .cnt(stk_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rd    <= '0;
            rsp_data  <= '0;
            illegal   <= 1'b0;
            err       <= 1'b0;
        end else begin
            illegal <= deq && (dec.op == OP_BAD);
            if ((push_en && stk_full) || (pop_en && stk_empty)) err <= 1'b1;
            if (pop_en && dec.want_rsp) begin
                rsp_valid <= 1'b1;
                rsp_rd    <= dec.rd;
                rsp_data  <= top_data;
            end else if (rsp_valid && rsp_ready) begin
                rsp_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/retstack_cop_chk.sv
`timescale 1ns/1ps
module retstack_cop_chk #(
    parameter int DEPTH = 1024,
    parameter int XW    = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [4:0]    rsp_rd,
    input logic [XW-1:0] rsp_data,
    input logic          illegal,
    input logic          err,
    input logic          deq,
    input logic [CW-1:0] stk_cnt
);
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_rd))); // R6
    AST_NO_DEQ_PENDING: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !deq); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= CW'(DEPTH)); // R8
    AST_ILLEGAL_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (stk_cnt == $past(stk_cnt))); // R7
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && ($past(stk_cnt) == '0)) |-> (rsp_data == '0)); // R9
endmodule

bind retstack_cop retstack_cop_chk #(.DEPTH(DEPTH), .XW(rsk_pkg::XLEN)) u_chk (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rd(rsp_rd), .rsp_data(rsp_data), .illegal(illegal), .err(err),
    .deq(deq), .stk_cnt(stk_cnt)
);

// File: tb/sim_retstack_cop.sv
`timescale 1ns/1ps
module sim_retstack_cop;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_inst = '0;
    logic [63:0] cmd_rs1 = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [4:0]  rsp_rd;
    logic [63:0] rsp_data;
    logic        illegal;
    logic        err;

    int n_chk = 0;
    int n_err = 0;
    int ill_cnt = 0;
    bit done = 0;

    localparam logic [31:0] PUSH5   = 32'h0002a00b;
    localparam logic [31:0] POP5    = 32'h0200428b;
    localparam logic [31:0] POP9    = 32'h0200448b;
    localparam logic [31:0] POP_NX  = 32'h0200028b;
    localparam logic [31:0] BAD_F7  = 32'h0400000b;
    localparam logic [31:0] BAD_OPC = 32'h0002a02b;

    always #2.5 clk = ~clk;

    retstack_cop #(.DEPTH(DEPTH), .QDEPTH(4)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_inst(cmd_inst), .cmd_rs1(cmd_rs1), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_rd(rsp_rd), .rsp_data(rsp_data),
        .illegal(illegal), .err(err)
    );

    always @(negedge clk) if (illegal) ill_cnt++;

    typedef struct packed {
        logic [31:0] inst;
        logic [63:0] rs1;
        logic        rsp;
        logic [4:0]  rd;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{PUSH5, 64'h0000_0000_8000_1000, 1'b0, 5'd0, 64'h0},
        '{PUSH5, 64'h0000_0000_8000_2040, 1'b0, 5'd0, 64'h0},
        '{POP5,  64'h0,                   1'b1, 5'd5, 64'h0000_0000_8000_2040},
        '{PUSH5, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 5'd0, 64'h0},
        '{POP9,  64'h0,                   1'b1, 5'd9, 64'hFFFF_FFFF_FFFF_FFF0},
        '{POP5,  64'h0,                   1'b1, 5'd5, 64'h0000_0000_8000_1000},
        '{POP9,  64'h0,                   1'b1, 5'd9, 64'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] inst, input logic [63:0] rs1);
        int w = 0;
        while (!cmd_ready && w < 2000) begin
            @(negedge clk);
            w++;
        end
        cmd_valid = 1'b1;
        cmd_inst  = inst;
        cmd_rs1   = rs1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic get_rsp(input logic [4:0] erd, input logic [63:0] edata, input string req);
        int w = 0;
        while (!rsp_valid && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk(rsp_valid, req, 64'(rsp_valid), 64'h1);
        chk(rsp_rd == erd, req, 64'(rsp_rd), 64'(erd));
        chk(rsp_data == edata, req, rsp_data, edata);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(cmd_ready == 1'b1, "R10 ready after reset", 64'(cmd_ready), 64'h1);
        chk(rsp_valid == 1'b0, "R10 no rsp after reset", 64'(rsp_valid), 64'h0);
        chk(err == 1'b0, "R10 err after reset", 64'(err), 64'h0);
        chk(illegal == 1'b0, "R10 illegal after reset", 64'(illegal), 64'h0);

        // R1 R2 R3 R9: vector table
        for (int i = 0; i < NV; i++) begin
            send(VEC[i].inst, VEC[i].rs1);
            if (VEC[i].rsp) get_rsp(VEC[i].rd, VEC[i].exp, "R3 vector pop");
            else begin
                idle(3);
                chk(rsp_valid == 1'b0, "R2 push silent", 64'(rsp_valid), 64'h0);
            end
        end
        chk(err == 1'b1, "R9 empty pop sets err", 64'(err), 64'h1);
        idle(5);
        chk(err == 1'b1, "R10 err sticky", 64'(err), 64'h1);

        // R10: reset clears err and empties stack
        do_reset();
        chk(err == 1'b0, "R10 err cleared", 64'(err), 64'h0);
        send(POP5, 64'h0);
        get_rsp(5'd5, 64'h0, "R10 stack empty after reset");

        // R1 R3: fixed words and response latency
        do_reset();
        send(PUSH5, 64'h1234);
        idle(2);
        send(POP5, 64'h0);
        chk(rsp_valid == 1'b0, "R3 rsp not yet", 64'(rsp_valid), 64'h0);
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R1 pop word answers next cycle", 64'(rsp_valid), 64'h1);
        get_rsp(5'd5, 64'h1234, "R1 fixed words round trip");

        // R4: silent pop
        send(PUSH5, 64'hAAAA);
        send(PUSH5, 64'hBBBB);
        send(POP_NX, 64'h0);
        idle(4);
        chk(rsp_valid == 1'b0, "R4 xd=0 pop silent", 64'(rsp_valid), 64'h0);
        send(POP9, 64'h0);
        get_rsp(5'd9, 64'hAAAA, "R4 xd=0 pop removed top");

        // R7: illegal commands
        send(PUSH5, 64'h7777);
        idle(2);
        ill_cnt = 0;
        send(BAD_F7, 64'h9999);
        idle(2);
        chk(ill_cnt == 1, "R7 bad funct7 pulse", 64'(ill_cnt), 64'h1);
        send(BAD_OPC, 64'h8888);
        idle(2);
        chk(ill_cnt == 2, "R7 bad opcode pulse", 64'(ill_cnt), 64'h2);
        send(POP5, 64'h0);
        get_rsp(5'd5, 64'h7777, "R7 stack unchanged");
        chk(err == 1'b0, "R7 no err", 64'(err), 64'h0);

        // R5 R6: stalled response with queue filling
        send(PUSH5, 64'h1);
        send(POP5, 64'h0);
        for (int k = 0; k < 4; k++) send(PUSH5, 64'(10 + k));
        idle(1);
        chk(cmd_ready == 1'b0, "R5 queue full", 64'(cmd_ready), 64'h0);
        chk(rsp_valid == 1'b1, "R6 rsp held", 64'(rsp_valid), 64'h1);
        chk(rsp_data == 64'h1, "R6 data held", rsp_data, 64'h1);
        idle(3);
        chk(rsp_data == 64'h1, "R6 data still held", rsp_data, 64'h1);
        get_rsp(5'd5, 64'h1, "R6 stalled rsp");
        send(PUSH5, 64'd14);
        for (int k = 4; k >= 0; k--) begin
            send(POP9, 64'h0);
            get_rsp(5'd9, 64'(10 + k), "R5 order kept");
        end

        // R8: overflow at DEPTH
        do_reset();
        for (int k = 0; k < DEPTH; k++) send(PUSH5, 64'(k + 100));
        idle(6);
        chk(err == 1'b0, "R8 full stack no err", 64'(err), 64'h0);
        send(PUSH5, 64'hDEAD);
        idle(3);
        chk(err == 1'b1, "R8 overflow err", 64'(err), 64'h1);
        send(POP5, 64'h0);
        get_rsp(5'd5, 64'(DEPTH - 1 + 100), "R8 overflow push dropped");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule